// File: doc/BRIEF.md
# Transaction Filter and Record Logger

This block sits between a bus-trace front end and an on-chip trace memory. It decides, once per bus transaction, whether that transaction's trace records go into the memory. Each transaction is a run of beats on `cyc_valid`/`cyc_data`, one beat per recorded bus cycle. The run ends with a single `txn_end` beat, which carries no cycle record; on that beat the block samples the three condition-match flags and the filter configuration. While the transaction is still open, its cycle records wait in a small staging buffer. At the closing beat the block either commits them, with a summary record appended, or throws them all away.

Committed records leave the staging buffer one per clock and become memory writes at a wrapping write pointer. Each summary record carries a timestamp from a free-running cycle counter. It also carries a flag that marks the timestamp as unusable when too long a gap has passed since the previous summary. After a final-trigger strobe, the block saves the memory address of the first summary record actually written. Once captured, that position holds until software re-arms the capture.

Top module: `tfl_logger`

## Requirements
- R1: A transaction judged "drop" at its `txn_end` beat causes no memory write at all: neither its cycle records nor a summary record.
- R2: A transaction judged "keep" writes all of its cycle records in arrival order and then one summary record, at consecutive memory addresses. The `txn_end` beat itself contributes no cycle record.
- R3: With `flt_on` low, every transaction is kept, whatever the condition flags and the other filter settings are.
- R4: With `flt_on` high and `flt_drop_mode` = 0, a transaction is kept exactly when some bit is set in both `cond_hit` and `cond_en`. If `cond_en` is all zero, nothing matches.
- R5: With `flt_on` high and `flt_drop_mode` = 1, a transaction is kept exactly when no bit is set in both `cond_hit` and `cond_en`.
- R6: Record format.
  - A cycle record has bit 31 = 0, bits 30:24 = 0 and bits 23:0 = the beat's `cyc_data`.
  - A summary record has bit 31 = 1, bit 30 = overflow flag and bits 29:23 = 0.
  - In a summary record, bits 22:0 hold the number of clock edges since reset ended, counted up to the clock edge that samples the `txn_end` beat. The count wraps at 2^23.
- R7: The overflow flag of a summary record is 1 exactly when the count of clock edges between this summary's `txn_end` edge and the previous kept summary's `txn_end` edge is 2^GAP_LOG or more. Before the first kept summary, the reference point is the end of reset.
- R8: After reset, the first memory write goes to address 0. Each later write goes to the next address, modulo 2^MEM_AW.
- R9: After a `final_trig` strobe, `trig_pos` takes the address of the first summary record written at or after that strobe, and `trig_pos_vld` rises. This holds even when the triggering transaction was dropped.
- R10: Once `trig_pos_vld` is set, further `final_trig` strobes leave `trig_pos` unchanged. A `trig_arm` pulse clears `trig_pos_vld` and allows one new capture.
- R11: Right after reset, `mem_we` is 0, `trig_pos_vld` is 0 and `trig_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A cycle record is present on this beat |
| cyc_data | input | 24 | Cycle record payload |
| txn_end | input | 1 | Closing beat of the transaction (no record) |
| cond_hit | input | 3 | Filter-condition match flags, sampled on `txn_end` |
| flt_on | input | 1 | Filter enable |
| flt_drop_mode | input | 1 | 0: keep matching transactions; 1: keep non-matching ones |
| cond_en | input | 3 | Which conditions take part in the match |
| final_trig | input | 1 | Final-trigger strobe |
| trig_arm | input | 1 | Re-arms trigger-position capture |
| mem_we | output | 1 | Trace memory write strobe |
| mem_addr | output | MEM_AW | Trace memory write address |
| mem_wdata | output | 32 | Trace record being written |
| trig_pos | output | MEM_AW | Address of first summary stored after trigger |
| trig_pos_vld | output | 1 | Trigger position captured |

## Verification
A table of transactions exercises the filter decision under different combinations of inputs:
- the filter off while condition flags are set;
- keep mode with a hit and with a miss;
- drop mode with a hit and with a miss;
- an empty condition enable;
- a transaction with no cycle records.

Together these separate an OR-of-enabled-matches decision from a plain OR of all the flags, and they show that the polarity is inverted in drop mode. Enough records are written to wrap the address space, and one long idle gap is placed against several short ones, so the overflow flag must follow the gap to the previous kept summary rather than to the previous transaction. Directed trigger sequences separate the two positions a capture could take: the triggering (dropped) transaction, or the first stored summary after it. They also separate a single capture per arm from one capture per strobe.

// File: rtl/tfl_pkg.sv
package tfl_pkg;

    localparam int REC_W = 32;
    localparam int TS_W  = 23;
    localparam int CYC_W = 24;
    localparam int NCOND = 3;

    typedef enum logic {
        FMODE_KEEP = 1'b0,
        FMODE_DROP = 1'b1
    } fmode_e;

    typedef struct packed {
        logic                     is_sum;
        logic                     ovr;
        logic [REC_W-TS_W-3:0]    pad;
        logic [TS_W-1:0]          ts;
    } sum_rec_t;

    typedef struct packed {
        logic                     is_sum;
        logic [REC_W-CYC_W-2:0]   pad;
        logic [CYC_W-1:0]         data;
    } cyc_rec_t;

    function automatic logic [REC_W-1:0] mk_sum(logic ovr, logic [TS_W-1:0] ts);
        sum_rec_t r;
        r.is_sum = 1'b1;
        r.ovr    = ovr;
        r.pad    = '0;
        r.ts     = ts;
        return r;
    endfunction

    function automatic logic [REC_W-1:0] mk_cyc(logic [CYC_W-1:0] data);
        cyc_rec_t r;
        r.is_sum = 1'b0;
        r.pad    = '0;
        r.data   = data;
        return r;
    endfunction

endpackage

// File: rtl/tfl_filter_decide.sv
module tfl_filter_decide
    import tfl_pkg::*;
(
    input  logic [NCOND-1:0] cond_hit,
    input  logic [NCOND-1:0] cond_en,
    input  logic             flt_on,
    input  fmode_e           flt_mode,
    output logic             keep
);

    logic any_hit;

    always_comb begin
        any_hit = |(cond_hit & cond_en);
        if (!flt_on) begin
            keep = 1'b1;
        end else begin
            case (flt_mode)
                FMODE_KEEP: keep = any_hit;
                FMODE_DROP: keep = ~any_hit;
                default:    keep = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/tfl_stamp.sv
module tfl_stamp
    import tfl_pkg::*;
#(
    parameter int GAP_LOG = 23
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    output logic [TS_W-1:0] ts,
    output logic            ovr
);

    localparam int GW = GAP_LOG + 1;

    logic [TS_W-1:0] ts_cnt;
    logic [GW-1:0]   gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_cnt  <= '0;
            gap_cnt <= '0;
        end else begin
            ts_cnt <= ts_cnt + 1'b1;
            if (take)
                gap_cnt <= GW'(1);
            else if (!gap_cnt[GAP_LOG])
                gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign ts  = ts_cnt;
    assign ovr = gap_cnt[GAP_LOG];

    // R7
    gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !ovr);

    // R6
    ts_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ts == $past(ts) + 1'b1));

endmodule

// File: rtl/tfl_stage.sv
module tfl_stage
    import tfl_pkg::*;
#(
    parameter int STG_AW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [REC_W-1:0] push_data,
    input  logic             close,
    input  logic             keep,
    input  logic [REC_W-1:0] sum_data,
    output logic             pop_valid,
    output logic [REC_W-1:0] pop_data
);

    localparam int DEPTH = 1 << STG_AW;

    logic [REC_W-1:0] buf_q [DEPTH];
    logic [STG_AW:0]  wr_ptr, cm_ptr, rd_ptr;
    logic [STG_AW:0]  occ;
    logic             wr_en;
    logic [REC_W-1:0] wr_data;

    assign wr_en   = push | (close & keep);
    assign wr_data = close ? sum_data : push_data;

    always_ff @(posedge clk) begin
        if (wr_en)
            buf_q[wr_ptr[STG_AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (close) begin
                if (keep) begin
                    wr_ptr <= wr_ptr + 1'b1;
                    cm_ptr <= wr_ptr + 1'b1;
                end else begin
                    wr_ptr <= cm_ptr;
                end
            end else if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_valid)
                rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign pop_valid = (rd_ptr != cm_ptr);
    assign pop_data  = buf_q[rd_ptr[STG_AW-1:0]];
    assign occ       = wr_ptr - rd_ptr;

    // R1
    drop_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        (close && !keep) |=> (wr_ptr == cm_ptr));

    // R2
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= (STG_AW+1)'(DEPTH));

endmodule

// File: rtl/tfl_trig_pos.sv
module tfl_trig_pos #(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              final_trig,
    input  logic              trig_arm,
    input  logic              sum_wr,
    input  logic [MEM_AW-1:0] wr_addr,
    output logic [MEM_AW-1:0] trig_pos,
    output logic              trig_vld
);

    logic pend;
    logic cap_done;
    logic hit_now;

    assign hit_now = sum_wr & (pend | final_trig) & ~cap_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            cap_done <= 1'b0;
            trig_pos <= '0;
        end else if (trig_arm) begin
            pend     <= 1'b0;
            cap_done <= 1'b0;
        end else if (hit_now) begin
            pend     <= 1'b0;
            cap_done <= 1'b1;
            trig_pos <= wr_addr;
        end else if (final_trig && !cap_done) begin
            pend <= 1'b1;
        end
    end

    assign trig_vld = cap_done;

    // R10
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_vld && !trig_arm) |=> $stable(trig_pos) && trig_vld);

    // R9
    pos_take_chk: assert property (@(posedge clk) disable iff (rst)
        (!trig_vld && !trig_arm && sum_wr && final_trig) |=> (trig_vld && trig_pos == $past(wr_addr)));

endmodule

// File: rtl/tfl_logger.sv
module tfl_logger
    import tfl_pkg::*;
#(
    parameter int MEM_AW  = 6,
    parameter int STG_AW  = 3,
    parameter int GAP_LOG = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_valid,
    input  logic [23:0]       cyc_data,
    input  logic              txn_end,
    input  logic [2:0]        cond_hit,
    input  logic              flt_on,
    input  logic              flt_drop_mode,
    input  logic [2:0]        cond_en,
    input  logic              final_trig,
    input  logic              trig_arm,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [MEM_AW-1:0] trig_pos,
    output logic              trig_pos_vld
);

    logic             keep;
    logic             push;
    logic             take;
    logic [TS_W-1:0]  ts;
    logic             ovr;
    logic             pop_valid;
    logic [REC_W-1:0] pop_data;
    logic [MEM_AW-1:0] wptr;
    sum_rec_t         out_view;

    tfl_filter_decide u_decide (
        .cond_hit (cond_hit),
        .cond_en  (cond_en),
        .flt_on   (flt_on),
        .flt_mode (fmode_e'(flt_drop_mode)),
        .keep     (keep)
    );

    assign push = cyc_valid & ~txn_end;
    assign take = txn_end & keep;

    tfl_stamp #(.GAP_LOG(GAP_LOG)) u_stamp (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .ts   (ts),
        .ovr  (ovr)
    );

    tfl_stage #(.STG_AW(STG_AW)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (mk_cyc(cyc_data)),
        .close     (txn_end),
        .keep      (keep),
        .sum_data  (mk_sum(ovr, ts)),
        .pop_valid (pop_valid),
        .pop_data  (pop_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            wptr      <= '0;
        end else begin
            mem_we <= pop_valid;
            if (pop_valid) begin
                mem_wdata <= pop_data;
                mem_addr  <= wptr;
                wptr      <= wptr + 1'b1;
            end
        end
    end

    assign out_view = mem_wdata;

    tfl_trig_pos #(.MEM_AW(MEM_AW)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .final_trig (final_trig),
        .trig_arm   (trig_arm),
        .sum_wr     (mem_we & out_view.is_sum),
        .wr_addr    (mem_addr),
        .trig_pos   (trig_pos),
        .trig_vld   (trig_pos_vld)
    );

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R1
    no_orphan_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(pop_valid));

endmodule

// File: tb/tfl_logger_tb.sv
module tfl_logger_tb;

    localparam int MAW = 4;
    localparam int GLG = 5;
    localparam int NV  = 10;
    // fields: [19:16] beats, [15:13] hit, [12] on, [11] drop mode, [10:8] enables, [7:0] idle
    localparam logic [19:0] VECS [NV] = '{
        {4'd3, 3'b101, 1'b0, 1'b0, 3'b000, 8'd2},   // R3 filter off
        {4'd2, 3'b001, 1'b1, 1'b0, 3'b001, 8'd2},   // R4 keep, hit
        {4'd4, 3'b010, 1'b1, 1'b0, 3'b001, 8'd2},   // R4 keep, miss
        {4'd1, 3'b100, 1'b1, 1'b1, 3'b100, 8'd2},   // R5 drop, hit
        {4'd5, 3'b010, 1'b1, 1'b1, 3'b101, 8'd2},   // R5 drop, miss
        {4'd0, 3'b111, 1'b1, 1'b0, 3'b000, 8'd2},   // R4 no enables
        {4'd2, 3'b011, 1'b0, 1'b1, 3'b111, 8'd2},   // R3 off, drop mode ignored
        {4'd3, 3'b110, 1'b1, 1'b0, 3'b110, 8'd40},  // R7 long gap
        {4'd6, 3'b000, 1'b1, 1'b1, 3'b111, 8'd1},   // R5 no hits
        {4'd0, 3'b001, 1'b1, 1'b1, 3'b010, 8'd1}    // R2 summary only
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cyc_valid = 1'b0;
    logic [23:0]      cyc_data = '0;
    logic             txn_end = 1'b0;
    logic [2:0]       cond_hit = '0;
    logic             flt_on = 1'b0;
    logic             flt_drop_mode = 1'b0;
    logic [2:0]       cond_en = '0;
    logic             final_trig = 1'b0;
    logic             trig_arm = 1'b0;
    logic             mem_we;
    logic [MAW-1:0]   mem_addr;
    logic [31:0]      mem_wdata;
    logic [MAW-1:0]   trig_pos;
    logic             trig_pos_vld;

    int          n_chk = 0;
    int          n_bad = 0;
    int          tnow = 0;
    int          last_ts = 0;
    int          exp_tot = 0;
    int          exp_n = 0;
    int          last_sum_addr = 0;
    bit          done = 1'b0;
    logic [31:0] exp_q [256];

    always #2 clk = ~clk;

    tfl_logger #(.MEM_AW(MAW), .STG_AW(3), .GAP_LOG(GLG)) u_dut (
        .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_data(cyc_data),
        .txn_end(txn_end), .cond_hit(cond_hit), .flt_on(flt_on),
        .flt_drop_mode(flt_drop_mode), .cond_en(cond_en),
        .final_trig(final_trig), .trig_arm(trig_arm), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .trig_pos(trig_pos),
        .trig_pos_vld(trig_pos_vld)
    );

    always @(posedge clk) begin
        if (rst) tnow <= 0;
        else     tnow <= tnow + 1;
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (exp_n >= exp_tot) begin
                chk(1'b0, "R1 unexpected write", mem_wdata, 32'h0);
            end else begin
                chk(mem_addr == MAW'(exp_n), "R8 address", 32'(mem_addr), 32'(exp_n % 16));
                chk(mem_wdata == exp_q[exp_n], "R2 R6 record", mem_wdata, exp_q[exp_n]);
            end
            exp_n++;
        end
    end

    task automatic run_txn(int n, logic [2:0] hit, logic on, logic md, logic [2:0] en, int tag);
        logic [31:0] tmp [16];
        logic        kp;
        logic        ov;
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            cyc_valid = 1'b1;
            cyc_data  = 24'hC00000 | 24'(tag << 8) | 24'(b);
            tmp[b]    = {8'h00, cyc_data};
        end
        @(negedge clk);
        cyc_valid     = 1'b1;
        cyc_data      = 24'hFFFFFF;
        txn_end       = 1'b1;
        cond_hit      = hit;
        flt_on        = on;
        flt_drop_mode = md;
        cond_en       = en;
        if (!on)     kp = 1'b1;
        else if (!md) kp = |(hit & en);
        else         kp = ~|(hit & en);
        if (kp) begin
            for (int b = 0; b < n; b++) begin
                exp_q[exp_tot] = tmp[b];
                exp_tot++;
            end
            ov = (tnow - last_ts) >= (1 << GLG);
            exp_q[exp_tot] = {1'b1, ov, 7'b0, 23'(tnow)};
            last_sum_addr = exp_tot % 16;
            exp_tot++;
            last_ts = tnow;
        end
        @(negedge clk);
        txn_end   = 1'b0;
        cyc_valid = 1'b0;
        cond_hit  = '0;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_trig();
        @(negedge clk);
        final_trig = 1'b1;
        @(negedge clk);
        final_trig = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'(exp_n), 32'(exp_tot));
        finish_run();
    end

    initial begin
        int pos_a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(mem_we == 1'b0, "R11 write strobe", 32'(mem_we), 32'h0);
        chk(trig_pos_vld == 1'b0, "R11 position valid", 32'(trig_pos_vld), 32'h0);
        chk(trig_pos == '0, "R11 position", 32'(trig_pos), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VECS[i];
            repeat (int'(v[7:0])) @(negedge clk);
            run_txn(int'(v[19:16]), v[15:13], v[12], v[11], v[10:8], i);
        end
        chk(exp_n == exp_tot, "R1 R2 write count", 32'(exp_n), 32'(exp_tot));

        // R9 trigger then dropped transaction then kept transaction
        pulse_trig();
        run_txn(2, 3'b000, 1'b1, 1'b0, 3'b001, 20);
        chk(trig_pos_vld == 1'b0, "R9 no capture on dropped", 32'(trig_pos_vld), 32'h0);
        run_txn(1, 3'b000, 1'b0, 1'b0, 3'b000, 21);
        pos_a = last_sum_addr;
        chk(trig_pos_vld == 1'b1, "R9 valid", 32'(trig_pos_vld), 32'h1);
        chk(trig_pos == MAW'(pos_a), "R9 position", 32'(trig_pos), 32'(pos_a));

        // R10 second trigger without re-arm
        pulse_trig();
        run_txn(1, 3'b000, 1'b0, 1'b0, 3'b000, 22);
        chk(trig_pos == MAW'(pos_a), "R10 held position", 32'(trig_pos), 32'(pos_a));
        chk(trig_pos_vld == 1'b1, "R10 held valid", 32'(trig_pos_vld), 32'h1);

        // R10 re-arm then capture again
        @(negedge clk);
        trig_arm = 1'b1;
        @(negedge clk);
        trig_arm = 1'b0;
        chk(trig_pos_vld == 1'b0, "R10 re-arm clears", 32'(trig_pos_vld), 32'h0);
        pulse_trig();
        run_txn(0, 3'b000, 1'b0, 1'b0, 3'b000, 23);
        chk(trig_pos_vld == 1'b1, "R10 recapture valid", 32'(trig_pos_vld), 32'h1);
        chk(trig_pos == MAW'(last_sum_addr), "R10 recapture position", 32'(trig_pos), 32'(last_sum_addr));

        repeat (20) @(negedge clk);
        chk(exp_n == exp_tot, "R2 final write count", 32'(exp_n), 32'(exp_tot));
        finish_run();
    end

endmodule